// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes and advances them once per second. A one-cycle `tick_i` pulse, arriving at the timebase rate, stands in for the oscillator. An internal prescaler counts `TICKS_PER_SEC` of those pulses and produces one step per second. On each step the seconds advance, and a carry ripples through minutes, hours, day of week, date, month and year. The carry rules cover 12-hour and 24-hour hour formats, months of 30 and 31 days, and February in common and leap years.

A host reaches the eight byte registers through a parallel port, by index. Writes land on the next clock edge. Reads are registered and return one cycle later. A halt flag held in the seconds byte freezes both the prescaler and all counting. Reset leaves the clock halted, so the host must clear the flag before time runs.

Register indices: 0 seconds (bit 7 halt, bits 6:0 BCD 00-59), 1 minutes (BCD 00-59), 2 hours, 3 day of week (1-7), 4 date (BCD 01-31), 5 month (BCD 01-12), 6 year (BCD 00-99), 7 control (plain storage byte).

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers at indices 0..7 read 0x80, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and 0x00, so the clock starts halted at 00:00:00 on day 1, 01/01/00.
- R2: While bit 7 of the seconds register is 1, no tick changes any register. Once the host clears that bit, counting resumes.
- R3: Ticks are counted while the clock runs. On every `TICKS_PER_SEC`-th tick the time steps by one second, in the same clock edge as that tick. Cycles without a tick change nothing.
- R4: Seconds and minutes count in BCD from 00 to 59. A wrap to 00 carries into the next field, and BCD digits roll from 9 to the next tens value (for example 09 becomes 10).
- R5: With hours bit 6 at 0 (24-hour mode), bits 5:0 count BCD 00 to 23. Bit 5 is the tens bit for hours 20-23. A step from 23:59:59 gives 00:00:00 and advances the day.
- R6: With hours bit 6 at 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 count 12, 01, ..., 11. A step from 11 to 12 toggles PM. Only 11 PM to 12 AM advances the day.
- R7: The day of week advances on each day change, runs 1 to 7 and wraps from 7 to 1.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. The wrap advances the month.
- R9: February (month 02) ends on 29 when the BCD year is divisible by 4 (00, 12, 24 ...) and on 28 otherwise.
- R10: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R11: A host write to index 0 clears the prescaler, so the next step comes after a full `TICKS_PER_SEC` ticks.
- R12: A write with `host_we_i` high updates register `host_idx_i` at the next edge. `host_rdata_o` shows register `host_idx_i` one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| host_we_i | input | 1 | Host write strobe |
| host_idx_i | input | IDX_W (3) | Register index |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Registered read data |

## Verification
The registers step in the same edge that samples the `TICKS_PER_SEC`-th tick. The bench therefore drives each tick for one edge from the falling clock edge and reads only after the last tick has been taken. Host writes take effect one edge after the strobe. Read data is due one edge after the index is presented, so every read sets the index at a falling edge and samples `host_rdata_o` at the next falling edge. Each calendar vector loads a state just short of a rollover and applies exactly one second of ticks. It then compares all seven time bytes against the expected state.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int REG_BYTES = 8;
  localparam int TIME_BYTES = 7;

  // BCD increment of a two-digit byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic bcd_leap(input logic [7:0] yr);
    return yr[1:0] == {yr[4], 1'b0};
  endfunction

  function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02: return bcd_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i && run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_i && run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  assert_after_step_R3: assert property (@(posedge clk) disable iff (rst)
    step_o |=> cnt_q == '0);
endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  logic [TIME_BYTES-1:0][7:0] cur_i,
  output logic [TIME_BYTES-1:0][7:0] nxt_o
);
  // carry[k] enters field k; seconds and minutes share one structure
  logic [2:0] carry;
  logic       day_c, mon_c, yr_c;
  logic [5:0] last_day;

  assign carry[0] = 1'b1;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_sixty
      logic at_max;
      assign at_max = cur_i[k][6:0] == 7'h59;
      assign carry[k+1] = carry[k] && at_max;
      assign nxt_o[k] = !carry[k] ? cur_i[k] :
                        at_max    ? {cur_i[k][7], 7'h00} :
                                    {cur_i[k][7], bcd_inc({1'b0, cur_i[k][6:0]})[6:0]};
    end
  endgenerate

  always_comb begin
    nxt_o[6:2] = cur_i[6:2];
    day_c = 1'b0;
    mon_c = 1'b0;
    yr_c  = 1'b0;
    last_day = month_end(cur_i[5][4:0], cur_i[6]);
    if (carry[2]) begin
      if (cur_i[2][6]) begin
        if (cur_i[2][4:0] == 5'h12) nxt_o[2] = {cur_i[2][7:5], 5'h01};
        else if (cur_i[2][4:0] == 5'h11) begin
          nxt_o[2] = {cur_i[2][7:6], ~cur_i[2][5], 5'h12};
          day_c = cur_i[2][5];
        end else nxt_o[2] = {cur_i[2][7:5], bcd_inc({3'b0, cur_i[2][4:0]})[4:0]};
      end else begin
        if (cur_i[2][5:0] == 6'h23) begin
          nxt_o[2] = {cur_i[2][7:6], 6'h00};
          day_c = 1'b1;
        end else nxt_o[2] = {cur_i[2][7:6], bcd_inc({2'b0, cur_i[2][5:0]})[5:0]};
      end
    end
    if (day_c) begin
      nxt_o[3] = (cur_i[3][2:0] >= 3'd7) ? 8'h01 : {5'b0, cur_i[3][2:0] + 3'd1};
      if (cur_i[4][5:0] == last_day) begin
        nxt_o[4] = 8'h01;
        mon_c = 1'b1;
      end else nxt_o[4] = {2'b0, bcd_inc({2'b0, cur_i[4][5:0]})[5:0]};
    end
    if (mon_c) begin
      if (cur_i[5][4:0] == 5'h12) begin
        nxt_o[5] = 8'h01;
        yr_c = 1'b1;
      end else nxt_o[5] = {3'b0, bcd_inc({3'b0, cur_i[5][4:0]})[4:0]};
    end
    if (yr_c) nxt_o[6] = (cur_i[6] == 8'h99) ? 8'h00 : bcd_inc(cur_i[6]);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int NREG = REG_BYTES,
  parameter int IDX_W = $clog2(REG_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o
);
  localparam logic [IDX_W-1:0] SEC_IDX = '0;

  logic [NREG-1:0][7:0]       rf;
  logic [TIME_BYTES-1:0][7:0] cur_t, nxt_t;
  logic                       step, sec_wr;

  assign sec_wr = host_we_i && (host_idx_i == SEC_IDX);
  assign cur_t  = rf[TIME_BYTES-1:0];

  rtc_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(!rf[0][7]),
    .clr_i(sec_wr), .step_o(step)
  );

  rtc_cal_advance u_adv (.cur_i(cur_t), .nxt_o(nxt_t));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
      rf[0] <= 8'h80;
      rf[3] <= 8'h01;
      rf[4] <= 8'h01;
      rf[5] <= 8'h01;
      host_rdata_o <= 8'h00;
    end else begin
      if (step) rf[TIME_BYTES-1:0] <= nxt_t;
      if (host_we_i) rf[host_idx_i] <= host_wdata_i;
      host_rdata_o <= rf[host_idx_i];
    end
  end

  assert_halt_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (rf[0][7] && !host_we_i) |=> $stable(rf));
  assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !host_we_i) |=> $stable(rf));
  assert_hour_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !host_we_i && !rf[2][6] && rf[2][5:0] <= 6'h23) |=> rf[2][5:0] <= 6'h23);
  assert_date_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !host_we_i && rf[4] != 8'h00) |=> rf[4] != 8'h00);
  assert_dow_range_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !host_we_i && rf[3][2:0] != 3'd0) |=> rf[3][2:0] != 3'd0);
endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int TPS = 4;
  localparam int NV = 14;
  // each entry: start {sec,min,hr,dow,date,mon,yr}, expected after one second
  localparam logic [111:0] VEC [NV] = '{
    {56'h12_34_05_03_15_06_24, 56'h13_34_05_03_15_06_24}, // R4
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R5 R7 R10
    {56'h59_59_09_02_30_04_21, 56'h00_00_10_02_30_04_21}, // R4
    {56'h59_59_23_02_30_04_21, 56'h00_00_00_03_01_05_21}, // R8
    {56'h59_59_23_04_30_07_21, 56'h00_00_00_05_31_07_21}, // R8
    {56'h59_59_23_05_31_01_21, 56'h00_00_00_06_01_02_21}, // R8
    {56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24}, // R9
    {56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23}, // R9
    {56'h59_59_23_06_29_02_00, 56'h00_00_00_07_01_03_00}, // R9
    {56'h59_59_23_06_28_02_10, 56'h00_00_00_07_01_03_10}, // R9
    {56'h59_59_71_03_10_03_21, 56'h00_00_52_04_11_03_21}, // R6
    {56'h59_59_51_03_10_03_21, 56'h00_00_72_03_10_03_21}, // R6
    {56'h59_59_72_03_10_03_21, 56'h00_00_61_03_10_03_21}, // R6
    {56'h59_59_19_03_10_03_21, 56'h00_00_20_03_10_03_21}  // R5
  };

  logic clk = 0, rst = 1, tick = 0, we = 0;
  logic [2:0] idx = 0;
  logic [7:0] wdata = 0, rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_rtc_calendar (
    .clk(clk), .rst(rst), .tick_i(tick), .host_we_i(we),
    .host_idx_i(idx), .host_wdata_i(wdata), .host_rdata_o(rdata)
  );

  function automatic string vtag(int i);
    case (i)
      0, 2: return "R4";
      1: return "R10";
      3, 4, 5: return "R8";
      6, 7, 8, 9: return "R9";
      10, 11, 12: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] i, logic [7:0] d);
    @(negedge clk); we = 1; idx = i; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] i, output logic [7:0] d);
    @(negedge clk); idx = i;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd_time(output logic [55:0] tm);
    logic [7:0] b;
    tm = '0;
    for (int k = 0; k < 7; k++) begin
      rd(3'(k), b);
      tm = {tm[47:0], b};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [55:0] tm;
    logic [7:0] rst_exp [8] = '{8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst = 0;
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), b);
      check("R1 reset value", 64'(b), 64'(rst_exp[k]));
    end
    // halted after reset
    ticks(8);
    rd(0, b); check("R2 halted seconds", 64'(b), 64'h80);
    // host access
    wr(7, 8'h93); rd(7, b); check("R12 control readback", 64'(b), 64'h93);
    wr(6, 8'h47); rd(6, b); check("R12 year readback", 64'(b), 64'h47);
    // run and prescale
    wr(0, 8'h00);
    ticks(3); rd(0, b); check("R3 before full second", 64'(b), 64'h00);
    ticks(1); rd(0, b); check("R3 after full second", 64'(b), 64'h01);
    repeat (20) @(negedge clk);
    rd(0, b); check("R3 no tick no change", 64'(b), 64'h01);
    // seconds write clears prescaler
    ticks(2); wr(0, 8'h30);
    ticks(3); rd(0, b); check("R11 prescaler cleared", 64'(b), 64'h30);
    ticks(1); rd(0, b); check("R11 step after full count", 64'(b), 64'h31);
    // halt mid-run then resume
    ticks(2); wr(0, 8'hC5);
    ticks(8); rd(0, b); check("R2 halt holds", 64'(b), 64'hC5);
    wr(0, 8'h45);
    ticks(4); rd(0, b); check("R2 resume after clear", 64'(b), 64'h46);
    // calendar vectors
    for (int v = 0; v < NV; v++) begin
      for (int k = 1; k < 7; k++) wr(3'(k), VEC[v][111 - 8*k -: 8]);
      wr(0, VEC[v][111:104]);
      ticks(TPS);
      rd_time(tm);
      check(vtag(v), 64'(tm), 64'(VEC[v][55:0]));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule